// File: doc/BRIEF.md
# Buffered Serial Master with Back-to-Back Frames

This block is the master side of an SPI-style serial link. Software loads an 8-bit word into a single data register. When the channel is enabled and the shifter is idle, the word moves into a shift register and a frame runs. While that frame runs, software may place the next word in the data register. The next frame then follows the current one with no idle time on the serial clock. Each frame transmits and receives at once. At frame end the received word is placed in the same data register, where software reads it.

A run-time mode input selects when the interrupt pulse fires. In one mode it fires when a pending word is taken into the shifter, which means the buffer has room again. In the other mode it fires when a frame finishes. Software typically runs a stream in buffer-empty mode and switches to transfer-end mode while the final word is shifting, so the last interrupt marks the end of the stream.

Only one clock format is provided. The clock idles high, data is launched on falling edges and captured on rising edges, and bits go most significant first. A parameter sets the number of system cycles per half period of the serial clock.

Top module: `spi_buf_master`

## Requirements
- R1: `buf_full_o` goes to 1 on the cycle after a write. It goes to 0 on the cycle after the pending word enters the shifter, unless a write arrives in that same cycle.
- R2: A write while `buf_full_o` is 1 replaces the pending word. Only the last word written is ever transmitted.
- R3: While a word is pending, `rd_data_o` returns that word and the running frame is unaffected. After a frame ends, `rd_data_o` holds the received word, unless a write arrives on that cycle.
- R4: A `start_i` pulse sets `enabled_o` and a `stop_i` pulse clears it; when both are high, stop wins. No frame begins while `enabled_o` is 0, but writes are still accepted.
- R5: `sck_o` idles at 1, and each frame opens with a falling edge. `sdo_o` changes only on falling edges and presents the MSB first. `sdi_i` is captured on each rising edge.
- R6: If `buf_full_o` is 1, the channel is enabled and the shifter is idle, a frame begins on the next edge. `busy_o` is then 1 for exactly 2*HALF_DIV*DATA_W cycles.
- R7: If a word is pending when a frame ends, the next frame begins on the same edge. `busy_o` stays 1 and no extra clock cycle is inserted.
- R8: With `irq_mode_i` = 0 (buffer-empty), `irq_o` is a one-cycle pulse in the first cycle after a pending word enters the shifter.
- R9: With `irq_mode_i` = 1 (transfer-end), `irq_o` is a one-cycle pulse in the first cycle after a frame's last bit completes.
- R10: `irq_mode_i` is sampled at each event. Changing it while a frame runs decides the kind of interrupt that frame's end produces.
- R11: A `stop_i` pulse aborts a running frame. On the next cycle `busy_o` is 0 and `sck_o` is 1, and the aborted frame raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: enable the channel |
| stop_i | input | 1 | Pulse: disable the channel and abort any frame |
| wr_en_i | input | 1 | Write strobe for the data register |
| wr_data_i | input | DATA_W | Word to transmit |
| rd_data_o | output | DATA_W | Data register contents (pending or received word) |
| irq_mode_i | input | 1 | 0: interrupt on buffer empty, 1: interrupt on transfer end |
| sck_o | output | 1 | Serial clock, idle high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | One-cycle interrupt pulse |
| buf_full_o | output | 1 | Data register holds a word not yet shifted |
| busy_o | output | 1 | A frame is in progress |
| enabled_o | output | 1 | Channel is enabled |

## Verification
The assertions are checked on every cycle. They cover these rules:
- A write always leaves the buffer full, and a move into the shifter empties it.
- Data out holds steady while the serial clock is high.
- No frame runs while the channel is disabled.
- A stop leaves the channel idle on the next cycle.
- The interrupt never lasts longer than one cycle.
- A pending word at frame end keeps busy high.

Other behaviours can only be shown by the bench's scenarios with data looped back:
- the bit order on the line;
- the exact frame length and interrupt position in each mode;
- the change of mode during the final frame of a three-word stream;
- overwriting a pending word;
- reading back the received words.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

  typedef enum logic {
    IRQ_ON_EMPTY = 1'b0,
    IRQ_ON_END   = 1'b1
  } irq_mode_e;

  // Pick the event that drives the interrupt for the current mode
  function automatic logic irq_pick(irq_mode_e mode, logic load_evt, logic end_evt);
    return (mode == IRQ_ON_END) ? end_evt : load_evt;
  endfunction

  // True when the shifter is free to accept a new word this cycle
  function automatic logic can_load(logic enabled, logic full, logic active,
                                    logic frame_end, logic stop);
    return enabled && full && !stop && (!active || frame_end);
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || restart || tick) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_ONLY_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              abort,
  input  logic              tick,
  input  logic              sdi,
  output logic              active,
  output logic              frame_end,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              sdo
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic              active_q;
  logic              high_q;   // 1 during the high half of a bit
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;

  logic rise_evt;
  logic fall_evt;

  assign rise_evt  = active_q && tick && !high_q;
  assign fall_evt  = active_q && tick && high_q && (bit_q != LAST_BIT);
  assign frame_end = active_q && tick && high_q && (bit_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      high_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= load_word;
    end else if (rise_evt) begin
      high_q <= 1'b1;
      rx_q   <= {rx_q[DATA_W-2:0], sdi};
    end else if (fall_evt) begin
      high_q <= 1'b0;
      bit_q  <= bit_q + 1'b1;
      tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
    end else if (frame_end) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
    end
  end

  assign active  = active_q;
  assign rx_word = rx_q;
  assign sck     = active_q ? high_q : 1'b1;
  assign sdo     = tx_q[DATA_W-1];

  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && high_q) |=> (!(active_q && high_q) || $stable(tx_q[DATA_W-1]))); // R5

  AST_RISE_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> high_q || !active_q); // R5

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_mode_i,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              irq_o,
  output logic              buf_full_o,
  output logic              busy_o,
  output logic              enabled_o
);
  logic              enabled_q;
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              irq_q;

  logic              tick;
  logic              active;
  logic              frame_end;
  logic [DATA_W-1:0] rx_word;
  logic              load_evt;
  logic              end_evt;

  assign load_evt = can_load(enabled_q, full_q, active, frame_end, stop_i);
  assign end_evt  = frame_end && !stop_i;

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .restart (load_evt),
    .tick    (tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_word (data_q),
    .abort     (stop_i),
    .tick      (tick),
    .sdi       (sdi_i),
    .active    (active),
    .frame_end (frame_end),
    .rx_word   (rx_word),
    .sck       (sck_o),
    .sdo       (sdo_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enabled_q <= 1'b0;
    else if (stop_i)  enabled_q <= 1'b0;
    else if (start_i) enabled_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_en_i)       full_q <= 1'b1;
      else if (load_evt) full_q <= 1'b0;
      if (wr_en_i)       data_q <= wr_data_i;
      else if (end_evt)  data_q <= rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_pick(irq_mode_e'(irq_mode_i), load_evt, end_evt);
  end

  assign rd_data_o  = data_q;
  assign irq_o      = irq_q;
  assign buf_full_o = full_q;
  assign busy_o     = active;
  assign enabled_o  = enabled_q;

  AST_WRITE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> buf_full_o); // R1

  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en_i) |=> !buf_full_o); // R1

  AST_OFF_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled_o |-> !busy_o); // R4

  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!busy_o && !enabled_o && sck_o)); // R11

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && buf_full_o && enabled_o && !stop_i) |=> busy_o); // R7

endmodule

// File: tb/tb_spi_buf_master.sv
module tb_spi_buf_master;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int H  = 3;
  localparam int FR = 2 * H * W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, stop_i = 1'b0, wr_en_i = 1'b0, irq_mode_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic         sck_o, sdo_o, irq_o, buf_full_o, busy_o, enabled_o;
  int           checks = 0, fails = 0, cyc = 0;

  spi_buf_master #(.DATA_W(W), .HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_mode_i(irq_mode_i), .sck_o(sck_o), .sdo_o(sdo_o), .sdi_i(sdo_o),
    .irq_o(irq_o), .buf_full_o(buf_full_o), .busy_o(busy_o), .enabled_o(enabled_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected line level for offset k within a frame of word w
  function automatic logic exp_sck(int k);
    return (k % (2*H)) >= H;
  endfunction
  function automatic logic exp_sdo(logic [W-1:0] w, int k);
    return w[W-1-(k/(2*H))];
  endfunction

  task automatic write_word(input logic [W-1:0] w);
    wr_data_i = w; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_busy(input string req);
    int n = 0;
    while (!busy_o && n < 10) begin @(negedge clk); n++; end
    check(busy_o, req, busy_o, 1);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    @(negedge clk);
    while (!irq_o && n < 3*FR) begin @(negedge clk); n++; end
    check(irq_o, req, irq_o, 1);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    $display("FAIL watchdog actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] w0, w1, w2, a, b, c;
    int t0;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R1 R4 R5
    check(!buf_full_o && !busy_o && !enabled_o && !irq_o, "R1 reset flags",
          {buf_full_o, busy_o, enabled_o, irq_o}, 0);
    check(sck_o == 1'b1, "R5 clock idles high", sck_o, 1);

    // Overwrite while disabled: R2 R4
    a = 8'h3C; b = 8'hA5; c = 8'h96;
    write_word(a);
    write_word(b);
    check(buf_full_o && rd_data_o == b, "R2 pending replaced", rd_data_o, b);
    repeat (4) @(negedge clk);
    check(!busy_o && buf_full_o, "R4 no frame while disabled", busy_o, 0);

    // Transfer-end mode, pending read during frame, back-to-back: R3 R4 R7 R9
    irq_mode_i = 1'b1;
    pulse_start();
    check(enabled_o, "R4 start enables", enabled_o, 1);
    wait_busy("R6 frame begins");
    t0 = cyc;
    check(!buf_full_o, "R1 load empties buffer", buf_full_o, 0);
    write_word(c);
    check(rd_data_o == c && busy_o && buf_full_o, "R3 pending readback", rd_data_o, c);
    wait_irq("R9 end irq");
    check(cyc - t0 == FR, "R9 end irq timing", cyc - t0, FR);
    check(rd_data_o == b, "R3 received word", rd_data_o, b);
    check(busy_o && !buf_full_o, "R7 next frame without gap", busy_o, 1);
    wait_irq("R9 second end irq");
    check(cyc - t0 == 2*FR && !busy_o, "R7 two frames span", cyc - t0, 2*FR);
    check(rd_data_o == c, "R3 second received word", rd_data_o, c);

    // Continuous stream in empty mode, switch at last word: R7 R8 R10
    irq_mode_i = 1'b0;
    w0 = 8'h81; w1 = 8'h7E; w2 = 8'hC3;
    write_word(w0);
    wait_irq("R8 empty irq");
    check(busy_o, "R8 irq with load", busy_o, 1);
    t0 = cyc;
    write_word(w1);
    wait_irq("R8 second empty irq");
    check(cyc - t0 == FR && busy_o, "R7 reload on frame end", cyc - t0, FR);
    check(rd_data_o == w0, "R3 rx of first word", rd_data_o, w0);
    write_word(w2);
    wait_irq("R8 third empty irq");
    check(rd_data_o == w1, "R3 rx of second word", rd_data_o, w1);
    irq_mode_i = 1'b1;
    wait_irq("R10 end irq after mode change");
    check(cyc - t0 == 3*FR, "R10 last irq at frame end", cyc - t0, 3*FR);
    check(!busy_o && rd_data_o == w2, "R10 stream finished", rd_data_o, w2);

    // Random frames in both modes: R5 R6 R8 R9
    for (int r = 0; r < 8; r++) begin
      logic [W-1:0] w;
      logic m, shape_ok, irq_ok;
      w = W'($urandom);
      m = 1'($urandom % 2);
      irq_mode_i = m;
      write_word(w);
      @(negedge clk);
      check(busy_o, "R6 frame starts after write", busy_o, 1);
      shape_ok = 1'b1;
      irq_ok = 1'b1;
      for (int k = 0; k < FR; k++) begin
        if (sck_o != exp_sck(k) || sdo_o != exp_sdo(w, k) || !busy_o) shape_ok = 1'b0;
        if (irq_o != (m == 1'b0 && k == 0)) irq_ok = 1'b0;
        @(negedge clk);
      end
      check(shape_ok, "R5 line shape MSB first", sdo_o, w);
      check(irq_ok, "R8 irq only at load", m, 0);
      check(!busy_o && sck_o, "R6 frame length", busy_o, 0);
      check(irq_o == m, "R9 irq at end per mode", irq_o, m);
      check(rd_data_o == w, "R3 loopback word", rd_data_o, w);
      @(negedge clk);
    end

    // Stop mid-frame: R11 R4
    irq_mode_i = 1'b1;
    write_word(8'h55);
    wait_busy("R11 frame running");
    repeat (5) @(negedge clk);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    check(!busy_o && sck_o && !enabled_o, "R11 stop aborts", {busy_o, sck_o, enabled_o}, 3'b010);
    begin
      logic seen = 1'b0;
      for (int k = 0; k < FR + 5; k++) begin
        if (irq_o) seen = 1'b1;
        @(negedge clk);
      end
      check(!seen, "R11 no irq after abort", seen, 0);
    end
    pulse_start();
    check(enabled_o && !busy_o, "R4 restart with empty buffer", busy_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule